// File: doc/BRIEF.md
# Up/Down Auto-Reload Capture Timer

This block is a 16-bit timer/counter paired with a 16-bit register that serves two purposes. In reload mode it holds the reload value. In capture mode it holds the captured count. Counting advances by one on each cycle in which the clock-enable input `tick_en` is high and the run bit is set.

In reload mode the timer counts up by default. When down-counting is enabled, an external direction pin chooses up or down. Counting up past all-ones loads the stored reload value. Counting down reaches its end when the count equals the stored value, and then the count becomes all-ones. Either event raises a sticky overflow flag that can drive an interrupt.

An external trigger pin is synchronised with two flops and checked for falling edges. When the external-enable bit is set, a falling edge does one of two things:
- In capture mode it copies the running count into the capture register.
- In reload mode it reloads the count.

Each accepted edge also sets a separate event flag.

Software reaches the count, the reload/capture value, the control bits and the flags through a simple write port and a combinational read port.

The run bit and the mode bit live in a four-state mode machine:
- `ST_HALT_RLD`: stopped, reload mode.
- `ST_HALT_CAP`: stopped, capture mode.
- `ST_RUN_RLD`: counting, reload mode.
- `ST_RUN_CAP`: counting, capture mode.

Every control write moves the machine from its current state to the state that the written run and mode bits encode:
- run=0, mode=0 selects `ST_HALT_RLD`.
- run=0, mode=1 selects `ST_HALT_CAP`.
- run=1, mode=0 selects `ST_RUN_RLD`.
- run=1, mode=1 selects `ST_RUN_CAP`.

With no control write, the state holds.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset, all four locations read 0 and both flag outputs are low. The locations are: address 0 count, address 1 reload/capture, address 2 control, address 3 flags.
- R2: In reload mode with the run bit set (control bit 0) and down-counting disabled, the count rises by one for each cycle with `tick_en` high.
- R3: Counting up from 0xFFFF in reload mode loads the count from the reload/capture register and sets the overflow flag (flags bit 0).
- R4: With down-counting enabled (control bit 3), the count falls while `dir_pin` is low and rises while it is high. With down-counting disabled, `dir_pin` has no effect.
- R5: Counting down in reload mode when the count equals the reload/capture register loads 0xFFFF and sets the overflow flag.
- R6: The overflow flag stays set until software writes 0 to flags bit 0.
- R7: While the run bit is clear, `tick_en` does not change the count.
- R8: In capture mode (control bit 1 = 1) with external enable set (control bit 2), a falling edge on `trig_pin` has these effects:
  - The count is copied into the reload/capture register.
  - The event flag (flags bit 1) is set.
  - The count itself is left unchanged.
- R9: With external enable clear, `trig_pin` edges change neither the reload/capture register nor the event flag.
- R10: In reload mode with external enable set, a falling edge on `trig_pin` loads the count from the reload/capture register and sets the event flag.
- R11: In capture mode the timer always counts up, whatever the direction settings. It wraps from 0xFFFF to 0 and sets the overflow flag, and the capture register is not changed by the wrap.
- R12: A software write to the count takes effect in place of an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable; one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| trig_pin | input | 1 | External trigger; falling edge acts |
| dir_pin | input | 1 | Count direction when down-counting is enabled (1 = up) |
| ovf_flag_o | output | 1 | Sticky overflow/underflow flag |
| ext_flag_o | output | 1 | Sticky external-event flag |

## Verification
The checker watches several properties on every cycle:
- The up-wrap reload and the down-wrap load of all-ones.
- The sticky overflow flag.
- The frozen count while stopped.
- The capture copy on an accepted edge.
- The event flag staying clear while the pin is disabled.
- The precedence of a software count write.

Some behaviours only the bench scenarios can show:
- The direction pin's effect only when down-counting is enabled.
- The two-flop delay before an edge acts.
- Capture-mode wrap to zero.
- The end-to-end sequences of write, count, flag and clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
    localparam logic [ADDR_W-1:0] A_RLD   = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;
    localparam logic [ADDR_W-1:0] A_FLAGS = 2'd3;

    localparam int C_RUN  = 0;
    localparam int C_CAP  = 1;
    localparam int C_EXT  = 2;
    localparam int C_DOWN = 3;

    localparam int F_OVF = 0;
    localparam int F_EXT = 1;

    typedef enum logic [1:0] {
        ST_HALT_RLD = 2'b00,
        ST_HALT_CAP = 2'b01,
        ST_RUN_RLD  = 2'b10,
        ST_RUN_CAP  = 2'b11
    } mode_state_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '1;
        end else begin
            shift_q <= {shift_q[DEPTH-2:0], pin_i};
        end
    end

    assign fall_o = shift_q[DEPTH-1] & ~shift_q[DEPTH-2];
endmodule

// File: rtl/tmr_mode_fsm.sv
module tmr_mode_fsm
    import tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic        run_bit,
    input  logic        cap_bit,
    output mode_state_t state_o,
    output logic        run_o,
    output logic        cap_o
);
    mode_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            unique case ({run_bit, cap_bit})
                2'b00: state_d = ST_HALT_RLD;
                2'b01: state_d = ST_HALT_CAP;
                2'b10: state_d = ST_RUN_RLD;
                2'b11: state_d = ST_RUN_CAP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT_RLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_HALT_RLD: begin run_o = 1'b0; cap_o = 1'b0; end
            ST_HALT_CAP: begin run_o = 1'b0; cap_o = 1'b1; end
            ST_RUN_RLD:  begin run_o = 1'b1; cap_o = 1'b0; end
            ST_RUN_CAP:  begin run_o = 1'b1; cap_o = 1'b1; end
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         up,
    input  logic         cap_mode,
    input  logic [W-1:0] reload_val,
    input  logic         sw_wr,
    input  logic [W-1:0] sw_val,
    input  logic         ext_load,
    output logic [W-1:0] count_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] ONES = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] count_q, count_d;
    logic         wrap_hit;

    always_comb begin
        wrap_hit = up ? (count_q == ONES) : (count_q == reload_val);
        wrap_o   = step_en && !sw_wr && !ext_load && wrap_hit;
    end

    always_comb begin
        count_d = count_q;
        if (sw_wr) begin
            count_d = sw_val;
        end else if (ext_load) begin
            count_d = reload_val;
        end else if (step_en) begin
            if (wrap_hit) begin
                if (cap_mode)  count_d = '0;
                else if (up)   count_d = reload_val;
                else           count_d = ONES;
            end else begin
                count_d = up ? count_q + ONE : count_q - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
    import tmr_pkg::*;
#(
    parameter int W         = 16,
    parameter int SYNC_FLOP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic              trig_pin,
    input  logic              dir_pin,
    output logic              ovf_flag_o,
    output logic              ext_flag_o
);
    mode_state_t state;
    logic        run, cap_mode;
    logic        ext_en, down_en;
    logic        ovf_q, ext_q;
    logic [W-1:0] count_q, reload_q;
    logic        trig_fall, trig_act, ext_load, cap_evt;
    logic        wr_cnt, wr_rld, wr_ctl, wr_flg;
    logic        up, step_en, wrap;

    assign wr_cnt = wr_en && (addr == A_COUNT);
    assign wr_rld = wr_en && (addr == A_RLD);
    assign wr_ctl = wr_en && (addr == A_CTRL);
    assign wr_flg = wr_en && (addr == A_FLAGS);

    tmr_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (wr_ctl),
        .run_bit (wdata[C_RUN]),
        .cap_bit (wdata[C_CAP]),
        .state_o (state),
        .run_o   (run),
        .cap_o   (cap_mode)
    );

    tmr_edge_sync #(.STAGES(SYNC_FLOP)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (trig_pin),
        .fall_o (trig_fall)
    );

    assign trig_act = trig_fall && ext_en;
    assign ext_load = trig_act && !cap_mode;
    assign cap_evt  = trig_act && cap_mode;
    assign up       = cap_mode || !down_en || dir_pin;
    assign step_en  = tick_en && run;

    tmr_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .up         (up),
        .cap_mode   (cap_mode),
        .reload_val (reload_q),
        .sw_wr      (wr_cnt),
        .sw_val     (wdata),
        .ext_load   (ext_load),
        .count_o    (count_q),
        .wrap_o     (wrap)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            ext_en   <= 1'b0;
            down_en  <= 1'b0;
            ovf_q    <= 1'b0;
            ext_q    <= 1'b0;
        end else begin
            if (wr_rld)       reload_q <= wdata;
            else if (cap_evt) reload_q <= count_q;

            if (wr_ctl) begin
                ext_en  <= wdata[C_EXT];
                down_en <= wdata[C_DOWN];
            end

            if (wrap)        ovf_q <= 1'b1;
            else if (wr_flg) ovf_q <= wdata[F_OVF];

            if (trig_act)    ext_q <= 1'b1;
            else if (wr_flg) ext_q <= wdata[F_EXT];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_COUNT: rdata = count_q;
            A_RLD:   rdata = reload_q;
            A_CTRL: begin
                rdata[C_RUN]  = (state == ST_RUN_RLD) || (state == ST_RUN_CAP);
                rdata[C_CAP]  = cap_mode;
                rdata[C_EXT]  = ext_en;
                rdata[C_DOWN] = down_en;
            end
            A_FLAGS: begin
                rdata[F_OVF] = ovf_q;
                rdata[F_EXT] = ext_q;
            end
        endcase
    end

    assign ovf_flag_o = ovf_q;
    assign ext_flag_o = ext_q;
endmodule

// File: rtl/updn_reload_timer_chk.sv
module updn_reload_timer_chk
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [W-1:0]      wdata,
    input logic              dir_pin,
    input logic              run,
    input logic              cap_mode,
    input logic              ext_en,
    input logic              down_en,
    input logic              trig_fall,
    input logic [W-1:0]      count_q,
    input logic [W-1:0]      reload_q,
    input logic              ovf_q,
    input logic              ext_q
);
    localparam logic [W-1:0] ONES = '1;

    logic wr_cnt, wr_rld, wr_flg, tact;
    assign wr_cnt = wr_en && (addr == A_COUNT);
    assign wr_rld = wr_en && (addr == A_RLD);
    assign wr_flg = wr_en && (addr == A_FLAGS);
    assign tact   = trig_fall && ext_en;

    AST_UP_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cap_mode && tick_en && (!down_en || dir_pin) && count_q == ONES && !wr_cnt && !tact)
        |=> (count_q == $past(reload_q)) && ovf_q); // R3

    AST_DOWN_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cap_mode && tick_en && down_en && !dir_pin && count_q == reload_q && !wr_cnt && !tact)
        |=> (count_q == ONES) && ovf_q); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !wr_flg) |=> ovf_q); // R6

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt && !(tact && !cap_mode)) |=> $stable(count_q)); // R7

    AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && tact && !wr_rld) |=> (reload_q == $past(count_q)) && ext_q); // R8

    AST_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en && !ext_q && !wr_flg) |=> !ext_q); // R9

    AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (count_q == $past(wdata))); // R12
endmodule

bind updn_reload_timer updn_reload_timer_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .dir_pin   (dir_pin),
    .run       (run),
    .cap_mode  (cap_mode),
    .ext_en    (ext_en),
    .down_en   (down_en),
    .trig_fall (trig_fall),
    .count_q   (count_q),
    .reload_q  (reload_q),
    .ovf_q     (ovf_q),
    .ext_q     (ext_q)
);

// File: tb/updn_reload_timer_tb.sv
`timescale 1ns/1ps
module updn_reload_timer_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         trig_pin = 1'b1;
    logic         dir_pin = 1'b0;
    logic         ovf_flag_o, ext_flag_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int           kind;
        logic [W-1:0] exp;
        string        tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    updn_reload_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .trig_pin   (trig_pin),
        .dir_pin    (dir_pin),
        .ovf_flag_o (ovf_flag_o),
        .ext_flag_o (ext_flag_o)
    );

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [W-1:0] act;
            it = sb_q.pop_front();
            if (it.kind == 0)      act = rdata;
            else if (it.kind == 1) act = {{(W-1){1'b0}}, ovf_flag_o};
            else                   act = {{(W-1){1'b0}}, ext_flag_o};
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        @(posedge clk); #1;
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    // kind 0 = read rdata at a, 1 = ovf_flag_o, 2 = ext_flag_o
    task automatic expect_item(input int kind, input logic [1:0] a,
                               input logic [W-1:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic trig_pulse();
        @(posedge clk); #1 trig_pin = 1'b0;
        repeat (4) @(posedge clk);
        #1 trig_pin = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_item(0, 2'd0, 16'h0000, "R1 count");
        expect_item(0, 2'd1, 16'h0000, "R1 reload");
        expect_item(0, 2'd2, 16'h0000, "R1 ctrl");
        expect_item(0, 2'd3, 16'h0000, "R1 flags");
        expect_item(1, 2'd0, 16'h0000, "R1 ovf pin");

        // R2/R3 up count and reload on overflow
        wr(2'd0, 16'hFFFD);
        wr(2'd1, 16'h1234);
        wr(2'd2, 16'h0001);
        tick(2);
        expect_item(0, 2'd0, 16'hFFFF, "R2 up count");
        expect_item(1, 2'd0, 16'h0000, "R2 no flag yet");
        tick(1);
        expect_item(0, 2'd0, 16'h1234, "R3 reload on overflow");
        expect_item(1, 2'd0, 16'h0001, "R3 flag set");

        // R6 sticky flag
        tick(3);
        expect_item(0, 2'd0, 16'h1237, "R2 count after reload");
        expect_item(1, 2'd0, 16'h0001, "R6 flag still set");
        wr(2'd3, 16'h0000);
        expect_item(0, 2'd3, 16'h0000, "R6 flag cleared");

        // R4/R5 down count and underflow
        wr(2'd2, 16'h0009);
        dir_pin = 1'b0;
        wr(2'd0, 16'h0102);
        wr(2'd1, 16'h0100);
        tick(2);
        expect_item(0, 2'd0, 16'h0100, "R4 down count");
        expect_item(1, 2'd0, 16'h0000, "R5 no flag before match");
        tick(1);
        expect_item(0, 2'd0, 16'hFFFF, "R5 underflow to ones");
        expect_item(1, 2'd0, 16'h0001, "R5 flag set");
        tick(1);
        expect_item(0, 2'd0, 16'hFFFE, "R4 keeps counting down");

        // R4 direction pin high counts up
        wr(2'd3, 16'h0000);
        dir_pin = 1'b1;
        wr(2'd0, 16'h0010);
        tick(3);
        expect_item(0, 2'd0, 16'h0013, "R4 dir high counts up");

        // R4 down disabled: dir ignored
        wr(2'd2, 16'h0001);
        dir_pin = 1'b0;
        tick(2);
        expect_item(0, 2'd0, 16'h0015, "R4 dir ignored without down enable");

        // R7 halted
        wr(2'd2, 16'h0000);
        tick(5);
        expect_item(0, 2'd0, 16'h0015, "R7 halted count holds");
        expect_item(0, 2'd2, 16'h0000, "R7 ctrl reads stopped");

        // R8 capture
        wr(2'd2, 16'h0006);
        wr(2'd0, 16'hABCD);
        wr(2'd1, 16'h0000);
        wr(2'd3, 16'h0000);
        trig_pulse();
        expect_item(0, 2'd1, 16'hABCD, "R8 capture value");
        expect_item(0, 2'd0, 16'hABCD, "R8 count unchanged");
        expect_item(0, 2'd3, 16'h0002, "R8 event flag");
        expect_item(2, 2'd0, 16'h0001, "R8 event pin");

        // R9 pin ignored
        wr(2'd2, 16'h0002);
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h1111);
        trig_pulse();
        expect_item(0, 2'd1, 16'hABCD, "R9 capture untouched");
        expect_item(0, 2'd3, 16'h0000, "R9 no event flag");

        // R10 external reload
        wr(2'd2, 16'h0004);
        wr(2'd1, 16'h5555);
        wr(2'd0, 16'h0001);
        wr(2'd3, 16'h0000);
        trig_pulse();
        expect_item(0, 2'd0, 16'h5555, "R10 external reload");
        expect_item(0, 2'd3, 16'h0002, "R10 event flag");

        // R11 capture mode wrap
        wr(2'd2, 16'h000B);
        wr(2'd3, 16'h0000);
        wr(2'd1, 16'h7777);
        wr(2'd0, 16'hFFFF);
        tick(2);
        expect_item(0, 2'd0, 16'h0001, "R11 wrap to zero and count up");
        expect_item(0, 2'd1, 16'h7777, "R11 capture reg kept");
        expect_item(0, 2'd3, 16'h0001, "R11 overflow flag");

        // R12 software write beats increment
        wr(2'd2, 16'h0001);
        @(posedge clk); #1;
        tick_en = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 16'h0100;
        @(posedge clk); #1;
        tick_en = 1'b0; wr_en = 1'b0;
        expect_item(0, 2'd0, 16'h0100, "R12 write wins");
        tick(1);
        expect_item(0, 2'd0, 16'h0101, "R12 counting resumes");

        repeat (2) @(posedge clk);
        done = 1'b1;
        report();
    end
endmodule